// File: doc/BRIEF.md
# Clear-to-Send Change-of-State Monitor

This block watches a raw, asynchronous, active-low clear-to-send pin and reports two facts about it through one 8-bit status byte. The first is a filtered copy of the pin's present level. The second is a sticky flag that records that the level has changed. The pin first passes through a two-flop synchroniser. A debounce counter then accepts a new level only after it has held for a programmable number of system clocks. At the 125 MHz bench clock the default of 4000 clocks is 32 µs, which sits inside the 25–50 µs qualification window.

After reset the block waits for two serial-clock ticks before the state bit starts to follow the pin. At that second tick it samples the filtered level once. If the line is already asserted at that point, it sets the flag. A read strobe clears the flag. An interrupt line is high while the flag is set and the enable input is high.

Top module: `cts_monitor`

## Requirements
- R1: Status layout: bit 4 is the change-of-state flag and bit 0 is the current-state bit. Bits 7:5 and 3:1 always read 0.
- R2: A new pin level counts only after the synchronised level has differed from the filtered level for FILT_CYCLES consecutive system clocks. A pulse of FILT_CYCLES-1 clocks changes neither the state bit nor the flag.
- R3: A read strobe returns the status as it stood during the strobe cycle and clears the flag on the following clock edge.
- R4: Once tracking has started, bit 0 reads 0 while the pin is low (asserted) and 1 while it is high (negated).
- R5: Before the second serial tick after reset, bit 0 reads 1 and no pin activity sets the flag.
- R6: At the second serial tick after reset, the flag is set if the filtered pin is asserted (low) and left clear if the pin is high.
- R7: The interrupt output is a level equal to flag AND enable. It drops when the flag is cleared or the enable is removed.
- R8: If a read strobe and a qualified level change fall in the same cycle, the flag stays set.
- R9: Synchronous active-high reset gives status 8'h01 and a low interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n_pin | input | 1 | Raw asynchronous clear-to-send pin, low = asserted |
| baud_tick | input | 1 | One-clock pulse per serial clock period |
| rd_stb | input | 1 | Status read strobe; clears the flag |
| irq_en | input | 1 | Interrupt enable |
| status_o | output | 8 | Status byte (bit 4 flag, bit 0 state) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a read strobe that lands in exactly the clock where the debounce counter accepts a new level (R8). A strobe one cycle early or one cycle late tests nothing. The bench changes the pin on a falling edge and counts the two synchroniser stages plus FILT_CYCLES filter clocks. It then raises the strobe for the cycle that ends at the accepting edge, and finally reads the status again to confirm that the flag survived. The pulse of FILT_CYCLES-1 clocks, one clock short of acceptance, is timed by the same count.

// File: rtl/cts_mon_pkg.sv
package cts_mon_pkg;

    localparam int STAT_W      = 8;
    localparam int START_TICKS = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_LIVE = 1'b1
    } start_e;

    typedef struct packed {
        logic [2:0] rsv_hi;
        logic       cos;
        logic [2:0] rsv_lo;
        logic       cur;
    } stat_t;

    function automatic stat_t pack_status(input logic cos, input logic cur);
        stat_t s;
        s        = '0;
        s.cos    = cos;
        s.cur    = cur;
        return s;
    endfunction

endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
    parameter int STAGES = cts_mon_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cts_filter.sv
module cts_filter #(
    parameter int FILT_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic s_i,
    output logic filt_o,
    output logic chg_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic          filt_q;
    logic [CW-1:0] cnt_q;
    logic          differs;

    assign differs = (s_i != filt_q);
    assign chg_o   = differs && (cnt_q == LAST);
    assign filt_o  = filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else if (!differs) begin
            cnt_q  <= '0;
        end else if (cnt_q == LAST) begin
            filt_q <= s_i;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R2: the filtered level moves only after a full window of differing samples
    p_flip_after_window_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> $past(cnt_q) == LAST);

    // R2: an input that agrees with the filtered level leaves it alone
    p_hold_when_equal_r2: assert property (@(posedge clk) disable iff (rst)
        (s_i == filt_q) |=> $stable(filt_q));
endmodule

// File: rtl/cts_startup.sv
module cts_startup
    import cts_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic live_o,
    output logic arm_o
);
    localparam int TW = $clog2(START_TICKS + 1);
    localparam logic [TW-1:0] TLAST = TW'(START_TICKS - 1);

    start_e        state_q;
    logic [TW-1:0] tcnt_q;

    assign arm_o  = (state_q == ST_WAIT) && tick_i && (tcnt_q == TLAST);
    assign live_o = (state_q == ST_LIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            tcnt_q  <= '0;
        end else if (arm_o) begin
            state_q <= ST_LIVE;
        end else if (state_q == ST_WAIT && tick_i) begin
            tcnt_q  <= tcnt_q + 1'b1;
        end
    end

    // R5: tracking, once started, never stops until reset
    p_live_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        live_o |=> live_o);

    // R6: the start-up sample point happens only once
    p_arm_once_r6: assert property (@(posedge clk) disable iff (rst)
        arm_o |=> !arm_o && live_o);
endmodule

// File: rtl/cts_cos_flag.sv
module cts_cos_flag (
    input  logic clk,
    input  logic rst,
    input  logic live_i,
    input  logic arm_i,
    input  logic chg_i,
    input  logic filt_i,
    input  logic rd_i,
    output logic cos_o
);
    logic cos_q;
    logic next_lvl;
    logic set;

    // level the filter holds after this edge
    assign next_lvl = filt_i ^ chg_i;
    assign set      = (live_i && chg_i) || (arm_i && !next_lvl);
    assign cos_o    = cos_q;

    always_ff @(posedge clk) begin
        if (rst)       cos_q <= 1'b0;
        else if (set)  cos_q <= 1'b1;
        else if (rd_i) cos_q <= 1'b0;
    end

    // R3: a read with nothing new arriving clears the flag
    p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !chg_i && !arm_i) |=> !cos_q);

    // R8: a qualified change while tracking always leaves the flag set
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (live_i && chg_i) |=> cos_q);

    // R5: before tracking starts the flag cannot rise except at the sample point
    p_no_early_set_r5: assert property (@(posedge clk) disable iff (rst)
        (!live_i && !arm_i) |=> !$rose(cos_q));
endmodule

// File: rtl/cts_monitor.sv
module cts_monitor
    import cts_mon_pkg::*;
#(
    parameter int FILT_CYCLES = 4000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cts_n_pin,
    input  logic        baud_tick,
    input  logic        rd_stb,
    input  logic        irq_en,
    output logic [7:0]  status_o,
    output logic        irq_o
);
    logic  s_sync;
    logic  filt;
    logic  chg;
    logic  live;
    logic  arm;
    logic  cos;
    stat_t stat;

    cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (cts_n_pin),
        .sync_o  (s_sync)
    );

    cts_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .s_i    (s_sync),
        .filt_o (filt),
        .chg_o  (chg)
    );

    cts_startup u_start (
        .clk    (clk),
        .rst    (rst),
        .tick_i (baud_tick),
        .live_o (live),
        .arm_o  (arm)
    );

    cts_cos_flag u_cos (
        .clk    (clk),
        .rst    (rst),
        .live_i (live),
        .arm_i  (arm),
        .chg_i  (chg),
        .filt_i (filt),
        .rd_i   (rd_stb),
        .cos_o  (cos)
    );

    assign stat     = pack_status(cos, live ? filt : 1'b1);
    assign status_o = stat;
    assign irq_o    = cos && irq_en;

    // R1: reserved positions stay zero
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        status_o[7:5] == 3'b000 && status_o[3:1] == 3'b000);

    // R7: the request only rises while enabled
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> irq_en);

    // R7: a read that clears the flag also drops the request
    p_irq_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !chg && !arm) |=> !irq_o);
endmodule

// File: tb/tb_cts_monitor.sv
module tb_cts_monitor;
    localparam int FILT = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cts_n_pin = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rd_stb = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] status_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    cts_monitor #(.FILT_CYCLES(FILT)) dut (
        .clk       (clk),
        .rst       (rst),
        .cts_n_pin (cts_n_pin),
        .baud_tick (baud_tick),
        .rd_stb    (rd_stb),
        .irq_en    (irq_en),
        .status_o  (status_o),
        .irq_o     (irq_o)
    );

    // serial tick: one pulse every 20 clocks, restarted by reset
    initial begin
        int tcnt;
        tcnt = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                tcnt = 0;
                baud_tick = 1'b0;
            end else begin
                tcnt = tcnt + 1;
                baud_tick = (tcnt % 20 == 0);
            end
        end
    end

    // monitor: compare status during every read strobe against the scoreboard
    always @(negedge clk) begin
        #1;
        if (rd_stb) begin
            item_t it;
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read: got %h expected none", status_o);
            end else begin
                it = sb_q.pop_front();
                if (status_o !== it.exp) begin
                    fails++;
                    $display("FAIL %s: status got %h expected %h", it.tag, status_o, it.exp);
                end
            end
        end
    end

    task automatic do_read(input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected under 50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // run A: line negated through start-up
        cts_n_pin = 1'b1;
        do_reset();
        #1;
        chk(status_o, 8'h01, "R9 reset status");
        chk({7'b0, irq_o}, 8'h00, "R9 reset irq");
        wait_n(60);
        do_read(8'h01, "R6 negated line at sample point leaves flag clear");

        // run B: line asserted from reset
        cts_n_pin = 1'b0;
        do_reset();
        wait_n(30);
        do_read(8'h01, "R5 state bit held at 1 before second tick");
        wait_n(30);
        do_read(8'h10, "R6 asserted line at sample point sets flag, R4 bit0=0");
        do_read(8'h00, "R3 flag cleared after read");

        // R2: pulse one clock short of the window
        cts_n_pin = 1'b1;
        wait_n(FILT - 1);
        cts_n_pin = 1'b0;
        wait_n(40);
        do_read(8'h00, "R2 short pulse ignored");

        // R2/R4/R7: qualified change to negated with interrupt gating
        irq_en = 1'b0;
        cts_n_pin = 1'b1;
        wait_n(40);
        #1;
        chk({7'b0, irq_o}, 8'h00, "R7 irq low while disabled");
        @(negedge clk);
        irq_en = 1'b1;
        #1;
        chk({7'b0, irq_o}, 8'h01, "R7 irq high when enabled with flag");
        @(negedge clk);
        irq_en = 1'b0;
        #1;
        chk({7'b0, irq_o}, 8'h00, "R7 irq drops when enable removed");
        @(negedge clk);
        irq_en = 1'b1;
        do_read(8'h11, "R2 long change accepted, R4 bit0=1");
        #1;
        chk({7'b0, irq_o}, 8'h00, "R7 irq drops after read clears flag");
        @(negedge clk);
        do_read(8'h01, "R3 flag clear after read, R1 reserved zero");

        // R8: read strobe in the very cycle the filter accepts a new level
        cts_n_pin = 1'b0;
        wait_n(FILT + 1);
        do_read(8'h01, "R8 status during colliding read");
        do_read(8'h10, "R8 new change wins over read");
        #1;
        chk({7'b0, irq_o}, 8'h00, "R7 irq low after final read");

        wait_n(2);
        chk(8'(sb_q.size()), 8'h00, "scoreboard drained");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule